// File: doc/BRIEF.md
# FWH/LPC Memory Target Front-End

This block is the target side of a 4-bit multiplexed firmware bus. The host shares one nibble-wide data path (LAD) and an active-low framing strobe (LFRAME) between two cycle formats: Firmware Hub memory cycles and LPC memory cycles. The block follows each cycle one nibble per clock. It recognises the start code, checks the ID or cycle-type nibble, shifts in the address and, for FWH, checks the size nibble. It then decodes the address into an array-or-register select and a 19-bit byte offset.

A claimed cycle raises a one-clock request toward the storage behind the block, and the block answers on LAD. Its answer is a short-wait sync, a ready sync, the read byte for reads, and a turnaround. A cycle that carries a wrong ID, a wrong strap, an unsupported cycle type or a wrong size gets no answer at all, and LAD stays released. Driving LFRAME low while a cycle is in progress aborts that cycle and releases LAD in the same clock. Flash command decoding and the storage itself are outside the block. Read data is presented on `rd_data` and is sampled during the final short-wait clock.

Top module: `fwh_lpc_target`

## Requirements
- R1: After a clock edge with `rst_n` low, `lad_oe` and `req_valid` are 0 and the block is idle.
- R2: The start code is the LAD value on the last clock on which `lframe_n` is low. 0000 opens an LPC cycle, 1101 an FWH read and 1110 an FWH write. Any other value is ignored.
- R3: In an FWH cycle, an ID nibble (the first nibble after the start) that differs from `id_strap` makes the block ignore the cycle: no request is made and LAD is never driven.
- R4: The FWH address is 7 nibbles, most significant first. A22=1 selects the array (`req_array`=1) and A22=0 selects registers. `req_offset` is A18..A0. A27..A23 and A21..A19 have no effect.
- R5: The FWH size nibble follows the address and must be 0000. Any other value drops the cycle with no request and no drive.
- R6: The LPC cycle-type nibble follows the start. 010x is a memory read and 011x is a memory write. Any other value leaves the cycle unclaimed.
- R7: The LPC address is 8 nibbles, most significant first. A23 selects the array (1) or registers (0), and `req_offset` is A18..A0. A22..A19 must equal `id_strap[3:0]`, or the cycle is not claimed. A31..A24 have no effect.
- R8: A claimed cycle gives exactly one clock of `req_valid`. For a read, the pulse comes in the clock after the last request nibble (size for FWH, last address for LPC). For a write, it comes in the clock after the second data nibble, with `req_wdata` built low nibble first.
- R9: After the request phase, LAD stays released for two clocks. It then carries 0101 for `WAIT_CLKS` clocks and 0000 for one clock. For a read, the data byte follows, low nibble first. LAD then carries 1111 for one clock and is released.
- R10: If `lframe_n` is low while a cycle is in progress, `lad_oe` is 0 in that clock and the cycle is discarded with no request. Later LAD values are taken as a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_strap | input | 4 | Board strap compared with the FWH ID nibble and LPC A22..A19 |
| lframe_n | input | 1 | Active-low cycle framing strobe |
| lad_in | input | 4 | LAD value received from the bus |
| lad_out | output | 4 | LAD value driven by the target |
| lad_oe | output | 1 | LAD drive enable (0 = high impedance) |
| rd_data | input | 8 | Read byte from array or registers, sampled in the last short-wait clock |
| req_valid | output | 1 | One-clock access request |
| req_write | output | 1 | Request is a write |
| req_array | output | 1 | 1 = memory array, 0 = register space |
| req_offset | output | 19 | Byte offset A18..A0 |
| req_wdata | output | 8 | Write byte |

## Verification
The bench drives complete FWH and LPC reads and writes with different strap values, nonzero don't-care address bits and both array and register targets. It compares LAD drive, LAD data and the request fields every clock against a behavioural model, which shows that the two address formats decode the select bit from different positions. Negative cycles use a wrong FWH ID, a nonzero size, a mismatched LPC strap, an I/O cycle type and an unknown start code. Each must leave LAD released and make no request, which tells each kind of rejection apart from a claim. Aborts in the address phase and in the middle of the sync show that a request is discarded before issue and that the drive drops in the same clock, and a leading low nibble before the real start shows that only the last framed nibble counts.

// File: rtl/fwh_lpc_pkg.sv
// Shared constants, phase encoding and helpers for the FWH/LPC target.
// Assumes a 4-bit LAD path and one nibble per clock.
package fwh_lpc_pkg;

    localparam int NIB_W         = 4;
    localparam int DEC_ADDR_W    = 24;   // A23..A0 are the only bits kept
    localparam int OFF_W         = 19;   // A18..A0
    localparam int FWH_ADDR_NIBS = 7;
    localparam int LPC_ADDR_NIBS = 8;
    localparam int TAR_CLKS      = 2;
    localparam int DATA_NIBS     = 2;

    localparam logic [NIB_W-1:0] START_LPC    = 4'b0000;
    localparam logic [NIB_W-1:0] START_FWH_RD = 4'b1101;
    localparam logic [NIB_W-1:0] START_FWH_WR = 4'b1110;
    localparam logic [NIB_W-1:0] SIZE_BYTE    = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_SHORT   = 4'b0101;
    localparam logic [NIB_W-1:0] SYNC_READY   = 4'b0000;
    localparam logic [NIB_W-1:0] LAD_PARK     = 4'b1111;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_FRAME,
        PH_ADDR,
        PH_SIZE,
        PH_WDATA,
        PH_HTAR,
        PH_WAIT,
        PH_READY,
        PH_RDATA,
        PH_TTAR
    } phase_t;

    // LPC cycle type: 01xx is a memory access, bit 1 gives the direction
    function automatic logic lpc_mem_type(input logic [NIB_W-1:0] t);
        return t[3:2] == 2'b01;
    endfunction

endpackage

// File: rtl/fwh_lpc_addr_dec.sv
// Address decoder: turns the assembled A23..A0 into a claim decision,
// an array/register select and a byte offset, for either cycle format.
// Assumes the FWH ID has already been checked by the cycle engine.
module fwh_lpc_addr_dec
    import fwh_lpc_pkg::*;
(
    input  logic                  is_lpc,
    input  logic [DEC_ADDR_W-1:0] addr,
    input  logic [NIB_W-1:0]      id_strap,
    output logic                  claim,
    output logic                  to_array,
    output logic [OFF_W-1:0]      offset
);

    // Pick the select bit and strap check by cycle format
    always_comb begin
        offset = addr[OFF_W-1:0];
        if (is_lpc) begin
            to_array = addr[23];
            claim    = (addr[22:19] == id_strap);
        end else begin
            to_array = addr[22];
            claim    = 1'b1;
        end
    end

endmodule

// File: rtl/fwh_lpc_cycle_fsm.sv
// Cycle engine: follows a framed cycle nibble by nibble, validates the
// START, ID / cycle-type and size fields, assembles the address and data,
// issues the one-clock request and sequences turnaround and sync phases.
// Assumes LFRAME low at any time restarts framing (abort).
module fwh_lpc_cycle_fsm
    import fwh_lpc_pkg::*;
#(
    parameter int WAIT_CLKS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lframe_n,
    input  logic [NIB_W-1:0]      lad_in,
    input  logic [NIB_W-1:0]      id_strap,
    input  logic                  dec_claim,
    input  logic                  dec_array,
    input  logic [OFF_W-1:0]      dec_offset,
    output logic [DEC_ADDR_W-1:0] addr_next,
    output logic                  is_lpc,
    output phase_t                phase,
    output logic                  cnt_zero,
    output logic                  req_valid,
    output logic                  req_write,
    output logic                  req_array,
    output logic [OFF_W-1:0]      req_offset,
    output logic [7:0]            req_wdata
);

    localparam int WAIT_W = $clog2(WAIT_CLKS + 1);
    localparam int CNT_W  = (WAIT_W > 4) ? WAIT_W : 4;

    logic [NIB_W-1:0]      start_q;
    logic                  is_write;
    logic [CNT_W-1:0]      cnt;
    logic [DEC_ADDR_W-1:0] addr_q;
    logic [NIB_W-1:0]      wlo_q;
    logic                  arr_q;
    logic [OFF_W-1:0]      off_q;
    logic [7:0]            wdata_q;

    // Address including the nibble on the bus this clock
    assign addr_next = {addr_q[DEC_ADDR_W-NIB_W-1:0], lad_in};
    // Shared counter has reached the last clock of the current phase
    assign cnt_zero  = (cnt == '0);

    // Cycle sequencing, field checks and request generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            start_q   <= LAD_PARK;
            is_lpc    <= 1'b0;
            is_write  <= 1'b0;
            cnt       <= '0;
            addr_q    <= '0;
            wlo_q     <= '0;
            arr_q     <= 1'b0;
            off_q     <= '0;
            wdata_q   <= '0;
            req_valid <= 1'b0;
        end else begin
            req_valid <= 1'b0;
            if (!lframe_n) begin
                phase   <= PH_FRAME;
                start_q <= lad_in;
            end else begin
                case (phase)
                    PH_FRAME: begin
                        if (start_q == START_FWH_RD || start_q == START_FWH_WR) begin
                            if (lad_in == id_strap) begin
                                phase    <= PH_ADDR;
                                is_lpc   <= 1'b0;
                                is_write <= (start_q == START_FWH_WR);
                                cnt      <= CNT_W'(FWH_ADDR_NIBS - 1);
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else if (start_q == START_LPC && lpc_mem_type(lad_in)) begin
                            phase    <= PH_ADDR;
                            is_lpc   <= 1'b1;
                            is_write <= lad_in[1];
                            cnt      <= CNT_W'(LPC_ADDR_NIBS - 1);
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_ADDR: begin
                        addr_q <= addr_next;
                        if (cnt_zero) begin
                            arr_q <= dec_array;
                            off_q <= dec_offset;
                            if (!is_lpc) begin
                                phase <= PH_SIZE;
                            end else if (!dec_claim) begin
                                phase <= PH_IDLE;
                            end else if (is_write) begin
                                phase <= PH_WDATA;
                                cnt   <= CNT_W'(DATA_NIBS - 1);
                            end else begin
                                phase     <= PH_HTAR;
                                cnt       <= CNT_W'(TAR_CLKS - 1);
                                req_valid <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    PH_SIZE: begin
                        if (lad_in != SIZE_BYTE) begin
                            phase <= PH_IDLE;
                        end else if (is_write) begin
                            phase <= PH_WDATA;
                            cnt   <= CNT_W'(DATA_NIBS - 1);
                        end else begin
                            phase     <= PH_HTAR;
                            cnt       <= CNT_W'(TAR_CLKS - 1);
                            req_valid <= 1'b1;
                        end
                    end
                    PH_WDATA: begin
                        if (!cnt_zero) begin
                            wlo_q <= lad_in;
                            cnt   <= cnt - CNT_W'(1);
                        end else begin
                            wdata_q   <= {lad_in, wlo_q};
                            req_valid <= 1'b1;
                            phase     <= PH_HTAR;
                            cnt       <= CNT_W'(TAR_CLKS - 1);
                        end
                    end
                    PH_HTAR: begin
                        if (!cnt_zero) begin
                            cnt <= cnt - CNT_W'(1);
                        end else begin
                            phase <= PH_WAIT;
                            cnt   <= CNT_W'(WAIT_CLKS - 1);
                        end
                    end
                    PH_WAIT: begin
                        if (!cnt_zero) cnt <= cnt - CNT_W'(1);
                        else           phase <= PH_READY;
                    end
                    PH_READY: begin
                        if (is_write) begin
                            phase <= PH_TTAR;
                            cnt   <= CNT_W'(TAR_CLKS - 1);
                        end else begin
                            phase <= PH_RDATA;
                            cnt   <= CNT_W'(DATA_NIBS - 1);
                        end
                    end
                    PH_RDATA: begin
                        if (!cnt_zero) begin
                            cnt <= cnt - CNT_W'(1);
                        end else begin
                            phase <= PH_TTAR;
                            cnt   <= CNT_W'(TAR_CLKS - 1);
                        end
                    end
                    PH_TTAR: begin
                        if (!cnt_zero) cnt <= cnt - CNT_W'(1);
                        else           phase <= PH_IDLE;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign req_write  = is_write;
    assign req_array  = arr_q;
    assign req_offset = off_q;
    assign req_wdata  = wdata_q;

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R8
    req_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (phase == PH_HTAR));

    // R3
    id_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FRAME && lframe_n &&
         (start_q == START_FWH_RD || start_q == START_FWH_WR) &&
         lad_in != id_strap) |=> (phase == PH_IDLE && !req_valid));

    // R5
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SIZE && lframe_n && lad_in != SIZE_BYTE)
        |=> (phase == PH_IDLE && !req_valid));

    // R7
    strap_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR && cnt_zero && is_lpc && lframe_n &&
         addr_next[22:19] != id_strap) |=> (phase == PH_IDLE && !req_valid));

endmodule

// File: rtl/fwh_lpc_resp_drv.sv
// Response driver: produces the LAD enable and nibble for the sync, data
// and turnaround phases and holds the read byte. Assumes rd_data is valid
// in the last short-wait clock. LAD is released at once while LFRAME is low.
module fwh_lpc_resp_drv
    import fwh_lpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lframe_n,
    input  phase_t           phase,
    input  logic             cnt_zero,
    input  logic [7:0]       rd_data,
    output logic             lad_oe,
    output logic [NIB_W-1:0] lad_out
);

    logic [7:0] rd_q;
    logic       drive;

    // Capture the read byte in the final short-wait clock
    always_ff @(posedge clk) begin
        if (!rst_n)                             rd_q <= '0;
        else if (phase == PH_WAIT && cnt_zero)  rd_q <= rd_data;
    end

    // Select drive and nibble for the current response phase
    always_comb begin
        drive   = 1'b0;
        lad_out = LAD_PARK;
        case (phase)
            PH_WAIT:  begin drive = 1'b1; lad_out = SYNC_SHORT; end
            PH_READY: begin drive = 1'b1; lad_out = SYNC_READY; end
            PH_RDATA: begin
                drive   = 1'b1;
                lad_out = cnt_zero ? rd_q[7:4] : rd_q[3:0];
            end
            PH_TTAR:  begin drive = !cnt_zero; lad_out = LAD_PARK; end
            default:  begin drive = 1'b0; lad_out = LAD_PARK; end
        endcase
    end

    assign lad_oe = drive && lframe_n;

    // R10
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |=> !lad_oe);

    // R9
    first_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> (lad_out == SYNC_SHORT));

    // R9
    park_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TTAR && lad_oe) |=> !lad_oe);

endmodule

// File: rtl/fwh_lpc_target.sv
// Top of the FWH/LPC memory target front-end: ties the cycle engine,
// address decoder and response driver together. Assumes LAD is split into
// in/out/enable by a pad outside this block.
module fwh_lpc_target
    import fwh_lpc_pkg::*;
#(
    parameter int WAIT_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  id_strap,
    input  logic        lframe_n,
    input  logic [3:0]  lad_in,
    output logic [3:0]  lad_out,
    output logic        lad_oe,
    input  logic [7:0]  rd_data,
    output logic        req_valid,
    output logic        req_write,
    output logic        req_array,
    output logic [18:0] req_offset,
    output logic [7:0]  req_wdata
);

    logic [DEC_ADDR_W-1:0] addr_next;
    logic                  is_lpc;
    phase_t                phase;
    logic                  cnt_zero;
    logic                  dec_claim;
    logic                  dec_array;
    logic [OFF_W-1:0]      dec_offset;

    fwh_lpc_cycle_fsm #(.WAIT_CLKS(WAIT_CLKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lframe_n   (lframe_n),
        .lad_in     (lad_in),
        .id_strap   (id_strap),
        .dec_claim  (dec_claim),
        .dec_array  (dec_array),
        .dec_offset (dec_offset),
        .addr_next  (addr_next),
        .is_lpc     (is_lpc),
        .phase      (phase),
        .cnt_zero   (cnt_zero),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_array  (req_array),
        .req_offset (req_offset),
        .req_wdata  (req_wdata)
    );

    fwh_lpc_addr_dec u_dec (
        .is_lpc   (is_lpc),
        .addr     (addr_next),
        .id_strap (id_strap),
        .claim    (dec_claim),
        .to_array (dec_array),
        .offset   (dec_offset)
    );

    fwh_lpc_resp_drv u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .lframe_n (lframe_n),
        .phase    (phase),
        .cnt_zero (cnt_zero),
        .rd_data  (rd_data),
        .lad_oe   (lad_oe),
        .lad_out  (lad_out)
    );

endmodule

// File: tb/fwh_lpc_target_test.sv
module fwh_lpc_target_test;

    localparam int WAIT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  id_strap = 4'hA;
    logic        lframe_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [7:0]  rd_data = 8'h00;
    logic        req_valid;
    logic        req_write;
    logic        req_array;
    logic [18:0] req_offset;
    logic [7:0]  req_wdata;

    int n_checks = 0;
    int n_fail   = 0;

    logic        e_wr;
    logic        e_arr;
    logic [18:0] e_off;
    logic [7:0]  e_wd;

    always #10 clk = ~clk;

    fwh_lpc_target #(.WAIT_CLKS(WAIT)) uut (
        .clk(clk), .rst_n(rst_n), .id_strap(id_strap), .lframe_n(lframe_n),
        .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe), .rd_data(rd_data),
        .req_valid(req_valid), .req_write(req_write), .req_array(req_array),
        .req_offset(req_offset), .req_wdata(req_wdata)
    );

    function automatic logic [31:0] fwh_addr(input logic [3:0] top, input logic a23,
                                             input logic arr, input logic [2:0] mid,
                                             input logic [18:0] off);
        return {4'h0, top, a23, arr, mid, off};
    endfunction

    function automatic logic [31:0] lpc_addr(input logic [7:0] top, input logic arr,
                                             input logic [3:0] strap, input logic [18:0] off);
        return {top, arr, strap, off};
    endfunction

    // Apply one clock of inputs, compare the outputs of that clock
    task automatic step(input logic lf, input logic [3:0] ld, input logic eoe,
                        input logic [3:0] eout, input logic ereq, input string tag);
        logic ok;
        lframe_n = lf;
        lad_in   = ld;
        #2;
        n_checks++;
        ok = (lad_oe === eoe) && (!eoe || lad_out === eout) && (req_valid === ereq);
        if (ereq)
            ok = ok && (req_write === e_wr) && (req_array === e_arr) &&
                 (req_offset === e_off) && (!e_wr || req_wdata === e_wd);
        if (!ok) begin
            n_fail++;
            $display("FAIL %s t=%0t: oe=%b out=%h req=%b wr=%b arr=%b off=%h wd=%h | expected oe=%b out=%h req=%b wr=%b arr=%b off=%h wd=%h",
                     tag, $time, lad_oe, lad_out, req_valid, req_write, req_array, req_offset,
                     req_wdata, eoe, eout, ereq, e_wr, e_arr, e_off, e_wd);
        end
        @(negedge clk);
    endtask

    // Drive one framed cycle and compare against the behavioural model
    task automatic run(input logic [3:0] strap, input logic pre_en, input logic [3:0] pre_nib,
                       input logic [3:0] startn, input logic [3:0] second,
                       input logic [31:0] addr, input logic lpc, input logic [3:0] size,
                       input logic wr, input logic [7:0] wd, input logic claim,
                       input logic arr, input logic [18:0] off, input logic [7:0] rd,
                       input int abort_at, input string tag);
        logic [3:0] nib[$];
        int n_addr;
        int nn;
        int s;
        int total;
        logic aborted;
        id_strap = strap;
        rd_data  = rd;
        e_wr = wr; e_arr = arr; e_off = off; e_wd = wd;
        n_addr = lpc ? 8 : 7;
        nib.push_back(second);
        for (int i = n_addr - 1; i >= 0; i--) nib.push_back(addr[4*i +: 4]);
        if (!lpc) nib.push_back(size);
        if (wr) begin
            nib.push_back(wd[3:0]);
            nib.push_back(wd[7:4]);
        end
        nn = nib.size();
        s = nn + 3;
        total = s + WAIT + (wr ? 0 : 2) + 2;
        aborted = 1'b0;
        if (pre_en) step(1'b0, pre_nib, 1'b0, 4'hF, 1'b0, tag);
        for (int c = 0; c <= total; c++) begin
            logic eoe;
            logic [3:0] eout;
            logic ereq;
            logic [3:0] ld;
            eoe = 1'b0; eout = 4'hF; ereq = 1'b0;
            if (c == abort_at) begin
                step(1'b0, 4'hF, 1'b0, 4'hF, 1'b0, tag);
                aborted = 1'b1;
                break;
            end
            if (claim) begin
                if (c == nn + 1) ereq = 1'b1;
                if (c >= s && c < s + WAIT) begin eoe = 1'b1; eout = 4'b0101; end
                else if (c == s + WAIT) begin eoe = 1'b1; eout = 4'b0000; end
                else if (!wr && c == s + WAIT + 1) begin eoe = 1'b1; eout = rd[3:0]; end
                else if (!wr && c == s + WAIT + 2) begin eoe = 1'b1; eout = rd[7:4]; end
                else if (c == s + WAIT + 1 + (wr ? 0 : 2)) begin eoe = 1'b1; eout = 4'hF; end
            end
            ld = (c == 0) ? startn : ((c <= nn) ? nib[c-1] : 4'hF);
            step((c == 0) ? 1'b0 : 1'b1, ld, eoe, eout, ereq, tag);
        end
        if (aborted) begin
            for (int k = 0; k < 4; k++) step(1'b1, 4'h0, 1'b0, 4'hF, 1'b0, tag);
        end
        step(1'b1, 4'hF, 1'b0, 4'hF, 1'b0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung, expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        e_wr = 1'b0; e_arr = 1'b0; e_off = '0; e_wd = '0;
        repeat (3) @(negedge clk);
        // R1: state after reset edges, still in reset
        step(1'b1, 4'hF, 1'b0, 4'hF, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        step(1'b1, 4'hF, 1'b0, 4'hF, 1'b0, "R1 after reset");
        step(1'b1, 4'h0, 1'b0, 4'hF, 1'b0, "R1 idle");

        // R4 R9: FWH read of array, don't-care bits set
        run(4'hA, 1'b0, 4'h0, 4'b1101, 4'hA, fwh_addr(4'hF, 1'b1, 1'b1, 3'b101, 19'h2A5C3),
            1'b0, 4'b0000, 1'b0, 8'h00, 1'b1, 1'b1, 19'h2A5C3, 8'hA6, -1, "R4 R9 FWH read array");
        // R4 R8: FWH write to register space
        run(4'hA, 1'b0, 4'h0, 4'b1110, 4'hA, fwh_addr(4'h0, 1'b1, 1'b0, 3'b011, 19'h0001F),
            1'b0, 4'b0000, 1'b1, 8'h5E, 1'b1, 1'b0, 19'h0001F, 8'h00, -1, "R4 R8 FWH write register");
        // R2 R7: LPC read, a different nibble framed first
        run(4'hA, 1'b1, 4'b1110, 4'b0000, 4'b0100, lpc_addr(8'hFF, 1'b1, 4'hA, 19'h7FFFF),
            1'b1, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 19'h7FFFF, 8'h3C, -1, "R2 R7 LPC read array");
        // R6 R7 R8: LPC write (type 0111), register space
        run(4'hA, 1'b0, 4'h0, 4'b0000, 4'b0111, lpc_addr(8'h12, 1'b0, 4'hA, 19'h00000),
            1'b1, 4'h0, 1'b1, 8'hC3, 1'b1, 1'b0, 19'h00000, 8'h00, -1, "R6 R7 R8 LPC write register");
        // R3: FWH ID mismatch
        run(4'hA, 1'b0, 4'h0, 4'b1101, 4'h5, fwh_addr(4'h0, 1'b0, 1'b1, 3'b000, 19'h00100),
            1'b0, 4'b0000, 1'b0, 8'h00, 1'b0, 1'b0, 19'h0, 8'h77, -1, "R3 FWH ID mismatch");
        // R5: FWH bad size
        run(4'hA, 1'b0, 4'h0, 4'b1110, 4'hA, fwh_addr(4'h0, 1'b0, 1'b1, 3'b000, 19'h00200),
            1'b0, 4'b0100, 1'b1, 8'h11, 1'b0, 1'b0, 19'h0, 8'h00, -1, "R5 FWH bad size");
        // R7: LPC strap mismatch
        run(4'hA, 1'b0, 4'h0, 4'b0000, 4'b0100, lpc_addr(8'h00, 1'b1, 4'h5, 19'h01234),
            1'b1, 4'h0, 1'b0, 8'h00, 1'b0, 1'b0, 19'h0, 8'h55, -1, "R7 LPC strap mismatch");
        // R6: LPC I/O cycle type is not claimed
        run(4'hA, 1'b0, 4'h0, 4'b0000, 4'b0010, lpc_addr(8'h00, 1'b1, 4'hA, 19'h00010),
            1'b1, 4'h0, 1'b1, 8'h22, 1'b0, 1'b0, 19'h0, 8'h00, -1, "R6 LPC IO type ignored");
        // R2: unknown START code
        run(4'hA, 1'b0, 4'h0, 4'b0011, 4'hA, fwh_addr(4'h0, 1'b0, 1'b1, 3'b000, 19'h00040),
            1'b0, 4'b0000, 1'b0, 8'h00, 1'b0, 1'b0, 19'h0, 8'h99, -1, "R2 unknown START");
        // R10: abort in the address phase
        run(4'hA, 1'b0, 4'h0, 4'b1101, 4'hA, fwh_addr(4'h0, 1'b0, 1'b1, 3'b000, 19'h00ABC),
            1'b0, 4'b0000, 1'b0, 8'h00, 1'b1, 1'b1, 19'h00ABC, 8'h44, 4, "R10 abort in address");
        // R10: abort during the sync drive
        run(4'hA, 1'b0, 4'h0, 4'b0000, 4'b0101, lpc_addr(8'h00, 1'b1, 4'hA, 19'h00333),
            1'b1, 4'h0, 1'b0, 8'h00, 1'b1, 1'b1, 19'h00333, 8'h81, 13, "R10 abort during sync");
        // R4 R9: another strap, register read with high nibble F
        run(4'h3, 1'b0, 4'h0, 4'b1101, 4'h3, fwh_addr(4'h9, 1'b0, 1'b0, 3'b111, 19'h4F0F0),
            1'b0, 4'b0000, 1'b0, 8'h00, 1'b1, 1'b0, 19'h4F0F0, 8'hF0, -1, "R4 R9 FWH read strap 3");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule